// File: doc/BRIEF.md
# DDR2 Command Timing Checker

A passive monitor for a DDR2 SDRAM command bus. It samples chip select, the three strobe lines, the bank-select bits and the address lines on every rising clock edge. From these it keeps its own record of which of the eight banks hold an open row, and which row that is. It raises a sticky flag for each kind of command that breaks a bank-state rule or a minimum-spacing rule. It never drives the bus.

All spacing limits are parameters in whole clock cycles. To get one, divide the nanosecond limit by the clock period and round up; for example, 20 ns at 3.75 ns per clock becomes 6. A spacing of exactly the limit is legal. The checker decodes only five commands: ACTIVATE, READ, WRITE, PRECHARGE and mode-register LOAD. Every other encoding leaves the timing state alone. A command that breaks a rule still updates the tracked state, because the memory would still carry it out.

Top module: `ddr2_cmd_checker`

## Requirements
- R1: After a synchronous reset, `viol` reads 0 and `bank_open` reads 0. Every spacing timer counts as already satisfied, so any first command is legal.
- R2: A cycle with `cs_n` high is a deselect, whatever the other lines carry. A cycle with `cs_n` low and `ras_n`, `cas_n`, `we_n` all high is a no-op. Neither kind of cycle changes bank state, starts a timer or sets a flag.
- R3: Encodings are {ras_n,cas_n,we_n}. ACTIVATE is 011, READ is 101, WRITE is 100, PRECHARGE is 010 and LOAD is 000. An ACTIVATE sets `bank_open[ba]` and stores `addr` in slice `ba` of `open_row`, which is bits ba*ROW_W upward.
- R4: An ACTIVATE to a bank that is already open sets `viol[0]`.
- R5: An ACTIVATE fewer than T_RC cycles after the previous ACTIVATE to the same bank sets `viol[1]`.
- R6: An ACTIVATE to a different bank fewer than T_RRD cycles after the most recent ACTIVATE sets `viol[2]`.
- R7: An ACTIVATE that would make five ACTIVATEs inside a span of fewer than T_FAW cycles sets `viol[3]`. That is, it comes fewer than T_FAW cycles after the fourth-most-recent ACTIVATE.
- R8: A READ or WRITE to a bank with no open row sets `viol[4]`.
- R9: A READ or WRITE to an open bank fewer than T_RCD cycles after that bank's ACTIVATE sets `viol[5]`.
- R10: A LOAD issued while any bank is open sets `viol[6]`.
- R11: Any of the five decoded commands issued fewer than T_MRD cycles after a LOAD sets `viol[7]`.
- R12: A PRECHARGE with `addr[10]` high closes all banks. With `addr[10]` low it closes only bank `ba`.
- R13: A flag appears after the clock edge that samples the offending command. It then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank select |
| addr | input | ROW_W | Address lines; bit 10 selects all-bank precharge |
| viol | output | 8 | Sticky violation flags, one per rule as in R4 to R11 |
| bank_open | output | 8 | One bit per bank, set while a row is open |
| open_row | output | 8*ROW_W | Stored row of each bank, bank b in bits b*ROW_W upward |

## Verification
The rolling four-activate window is the hardest case to reach from the ports. A fifth ACTIVATE trips the window only if the four before it hit four distinct banks, respect the cross-bank spacing, and all fall inside the window, so that no other rule fires in its place. The stimulus spaces four ACTIVATEs to four banks exactly T_RRD apart. It places the fifth once inside the window and, after a fresh reset, once exactly at its edge. Every scenario starts from reset so that each sticky flag can be attributed to one command.

// File: rtl/ddr2_cmd_checker.sv
`timescale 1ns/1ps
module ddr2_cmd_checker #(
  parameter int ROW_W = 14,
  parameter int T_RC  = 15,
  parameter int T_RRD = 3,
  parameter int T_FAW = 14,
  parameter int T_RCD = 6,
  parameter int T_MRD = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_n,
  input  logic                  ras_n,
  input  logic                  cas_n,
  input  logic                  we_n,
  input  logic [2:0]            ba,
  input  logic [ROW_W-1:0]      addr,
  output logic [7:0]            viol,
  output logic [7:0]            bank_open,
  output logic [8*ROW_W-1:0]    open_row
);
  localparam int NBANK = 8;
  localparam int FAW_N = 4;
  localparam int M1  = (T_RC > T_RRD) ? T_RC : T_RRD;
  localparam int M2  = (M1 > T_FAW) ? M1 : T_FAW;
  localparam int M3  = (M2 > T_RCD) ? M2 : T_RCD;
  localparam int SAT = (M3 > T_MRD) ? M3 : T_MRD;
  localparam int CW  = $clog2(SAT + 1);
  localparam logic [CW-1:0] SATV = CW'(SAT);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] bank_age [NBANK];
  logic [CW-1:0] faw_age  [FAW_N];
  logic [CW-1:0] rrd_age, mrd_age;
  logic [2:0]    last_ba;
  logic [7:0]    hit;

  function automatic logic [CW-1:0] inc(input logic [CW-1:0] v);
    return (v == SATV) ? v : v + 1'b1;
  endfunction

  wire sel = !cs_n;
  wire act = sel & !ras_n &  cas_n &  we_n;
  wire rw  = sel &  ras_n & !cas_n;
  wire pre = sel & !ras_n &  cas_n & !we_n;
  wire lm  = sel & !ras_n & !cas_n & !we_n;
  wire exe = act | rw | pre | lm;
  wire is_open = bank_open[ba];

  assign hit[0] = act & is_open;
  assign hit[1] = act & (int'(bank_age[ba]) < T_RC);
  assign hit[2] = act & (ba != last_ba) & (int'(rrd_age) < T_RRD);
  assign hit[3] = act & (int'(faw_age[FAW_N-1]) < T_FAW);
  assign hit[4] = rw & !is_open;
  assign hit[5] = rw & is_open & (int'(bank_age[ba]) < T_RCD);
  assign hit[6] = lm & (|bank_open);
  assign hit[7] = exe & (int'(mrd_age) < T_MRD);

  always_ff @(posedge clk) begin
    if (rst) begin
      viol      <= '0;
      bank_open <= '0;
      open_row  <= '0;
      rrd_age   <= SATV;
      mrd_age   <= SATV;
      last_ba   <= '0;
      for (int b = 0; b < NBANK; b++) bank_age[b] <= SATV;
      for (int i = 0; i < FAW_N; i++) faw_age[i] <= SATV;
    end else begin
      viol    <= viol | hit;
      rrd_age <= inc(rrd_age);
      mrd_age <= inc(mrd_age);
      for (int b = 0; b < NBANK; b++) bank_age[b] <= inc(bank_age[b]);
      for (int i = 0; i < FAW_N; i++) faw_age[i] <= inc(faw_age[i]);
      if (act) begin
        bank_open[ba] <= 1'b1;
        open_row[ba*ROW_W +: ROW_W] <= addr;
        bank_age[ba] <= ONE;
        rrd_age <= ONE;
        last_ba <= ba;
        faw_age[0] <= ONE;
        for (int i = 1; i < FAW_N; i++) faw_age[i] <= inc(faw_age[i-1]);
      end
      if (pre) begin
        if (addr[10]) bank_open <= '0;
        else          bank_open[ba] <= 1'b0;
      end
      if (lm) mrd_age <= ONE;
    end
  end

  // R13: flags never drop outside reset
  a_r13_sticky: assert property (@(posedge clk) disable iff (rst)
    (viol != '0) |=> ((viol & $past(viol)) == $past(viol)));
  // R2: a deselected cycle leaves flags and bank state untouched
  a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (viol == $past(viol) && bank_open == $past(bank_open)));
  a_r4_act_open: assert property (@(posedge clk) disable iff (rst)
    (act && is_open) |=> viol[0]);
  a_r8_rw_closed: assert property (@(posedge clk) disable iff (rst)
    (rw && !is_open) |=> viol[4]);
  a_r10_lm_busy: assert property (@(posedge clk) disable iff (rst)
    (lm && bank_open != '0) |=> viol[6]);
  a_r12_pre_all: assert property (@(posedge clk) disable iff (rst)
    (pre && addr[10]) |=> (bank_open == '0));
  a_r3_act_opens: assert property (@(posedge clk) disable iff (rst)
    (act && !pre) |=> ($countones(bank_open) >= 1));
endmodule

// File: tb/ddr2_cmd_checker_tb.sv
`timescale 1ns/1ps
module ddr2_cmd_checker_tb;
  localparam int RW = 14;
  localparam logic [3:0] DES = 4'b1111, NOP = 4'b0111, ACT = 4'b0011,
                         RD = 4'b0101, WR = 4'b0100, PRE = 4'b0010, LM = 4'b0000;
  localparam logic [16:0] RS = {1'b1, DES, 3'd0, 1'b0, 8'h00};
  localparam logic [16:0] DS = {1'b0, DES, 3'd0, 1'b0, 8'h00};
  localparam int NV = 87;
  // {rst, cs_n ras_n cas_n we_n, ba, addr10, expected viol}
  localparam logic [16:0] VEC [NV] = '{
    RS, {1'b0,RD,3'd1,1'b0,8'h10}, {1'b0,WR,3'd2,1'b0,8'h10},                       // R8 R13
    RS, {1'b0,ACT,3'd3,1'b0,8'h00}, {1'b0,RD,3'd3,1'b0,8'h20}, {1'b0,DES,3'd0,1'b0,8'h20}, // R9 R13
    RS, {1'b0,ACT,3'd3,1'b0,8'h00}, {1'b0,NOP,3'd0,1'b0,8'h00}, DS, {1'b0,WR,3'd3,1'b0,8'h00}, // R9 R2
    RS, {1'b0,ACT,3'd0,1'b0,8'h00}, {1'b0,ACT,3'd0,1'b0,8'h03},                    // R4 R5
    RS, {1'b0,ACT,3'd0,1'b0,8'h00}, {1'b0,PRE,3'd0,1'b0,8'h00}, {1'b0,ACT,3'd0,1'b0,8'h02}, // R5
    RS, {1'b0,ACT,3'd0,1'b0,8'h00}, {1'b0,PRE,3'd0,1'b0,8'h00}, DS, DS, DS, DS,
        {1'b0,ACT,3'd0,1'b0,8'h00},                                                 // R5 edge
    RS, {1'b0,ACT,3'd1,1'b0,8'h00}, DS, {1'b0,ACT,3'd4,1'b0,8'h00}, {1'b0,PRE,3'd0,1'b1,8'h00},
        {1'b0,LM,3'd0,1'b0,8'h00}, DS, {1'b0,RD,3'd1,1'b0,8'h10},                  // R12 R10
    RS, {1'b0,ACT,3'd1,1'b0,8'h00}, DS, {1'b0,ACT,3'd4,1'b0,8'h00}, {1'b0,PRE,3'd1,1'b0,8'h00},
        DS, {1'b0,RD,3'd4,1'b0,8'h00}, {1'b0,RD,3'd1,1'b0,8'h10},                  // R12
    RS, {1'b0,ACT,3'd2,1'b0,8'h00}, {1'b0,LM,3'd0,1'b0,8'h40},                     // R10
    RS, {1'b0,ACT,3'd0,1'b0,8'h00}, {1'b0,ACT,3'd1,1'b0,8'h04},                    // R6
    RS, {1'b0,ACT,3'd0,1'b0,8'h00}, DS, {1'b0,ACT,3'd1,1'b0,8'h00},                // R6 edge
    RS, {1'b0,ACT,3'd0,1'b0,8'h00}, DS, {1'b0,ACT,3'd1,1'b0,8'h00}, DS,
        {1'b0,ACT,3'd2,1'b0,8'h00}, DS, {1'b0,ACT,3'd3,1'b0,8'h00}, DS,
        {1'b0,ACT,3'd4,1'b0,8'h08},                                                 // R7
    RS, {1'b0,ACT,3'd0,1'b0,8'h00}, DS, {1'b0,ACT,3'd1,1'b0,8'h00}, DS,
        {1'b0,ACT,3'd2,1'b0,8'h00}, DS, {1'b0,ACT,3'd3,1'b0,8'h00}, DS, DS, DS,
        {1'b0,ACT,3'd4,1'b0,8'h00},                                                 // R7 edge
    RS, {1'b0,LM,3'd0,1'b0,8'h00}, {1'b0,ACT,3'd0,1'b0,8'h80},                     // R11
    RS, {1'b0,LM,3'd0,1'b0,8'h00}, {1'b0,NOP,3'd0,1'b0,8'h00}, {1'b0,ACT,3'd0,1'b0,8'h00}, // R11 edge
    RS, {1'b0,ACT,3'd0,1'b0,8'h00}, {1'b0,4'b1000,3'd0,1'b0,8'h00},
        {1'b0,4'b1011,3'd0,1'b0,8'h00}, {1'b0,RD,3'd0,1'b0,8'h00}                  // R2
  };

  logic clk = 0, rst = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [2:0] ba = '0;
  logic [RW-1:0] addr = '0;
  logic [7:0] viol, bank_open;
  logic [8*RW-1:0] open_row;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ddr2_cmd_checker #(.ROW_W(RW), .T_RC(6), .T_RRD(2), .T_FAW(10), .T_RCD(3), .T_MRD(2)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .viol(viol), .bank_open(bank_open), .open_row(open_row));

  task automatic chk(input string req, input logic [RW-1:0] got, input logic [RW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic r, input logic [3:0] c, input logic [2:0] b, input logic [RW-1:0] a);
    @(negedge clk);
    rst = r; {cs_n, ras_n, cas_n, we_n} = c; ba = b; addr = a;
    @(posedge clk); #1;
  endtask

  initial begin
    step(1, DES, 0, 0); step(1, DES, 0, 0);
    chk("R1 viol", RW'(viol), '0);
    chk("R1 bank_open", RW'(bank_open), '0);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][16], VEC[i][15:12], VEC[i][11:9], RW'(14'h0155) | (RW'(VEC[i][8]) << 10));
      chk($sformatf("table row %0d", i), RW'(viol), RW'(VEC[i][7:0]));
    end
    // R3: row stored for its bank
    step(1, DES, 0, 0);
    step(0, ACT, 3'd5, 14'h2A3C);
    chk("R3 bank_open", RW'(bank_open), RW'(8'h20));
    chk("R3 open_row", open_row[5*RW +: RW], 14'h2A3C);
    // R12: single-bank close, then all-bank close
    step(0, DES, 0, 0);
    step(0, ACT, 3'd6, 14'h0011);
    step(0, PRE, 3'd5, 14'h0000);
    chk("R12 one bank", RW'(bank_open), RW'(8'h40));
    step(0, ACT, 3'd2, 14'h0022); step(0, DES, 0, 0);
    step(0, PRE, 3'd0, 14'h0400);
    chk("R12 all banks", RW'(bank_open), '0);
    chk("R12 no flag", RW'(viol), '0);
    // R13: flag held across idle cycles, cleared by reset
    step(0, DES, 0, 0); step(0, DES, 0, 0); step(0, DES, 0, 0);
    step(0, RD, 3'd1, 0);
    for (int i = 0; i < 20; i++) step(0, DES, 0, 0);
    chk("R13 held", RW'(viol), RW'(8'h10));
    step(1, DES, 0, 0);
    chk("R1 cleared", RW'(viol), '0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule